// File: doc/BRIEF.md
# Arithmetic Fault Router

This block takes the fault reports of one integer divide and of one floating-point operation per cycle and turns them into the requests that the rest of the core acts on. For a divide, an overflow can be absorbed into a sticky status bit when the overflow-mask enable is set. Any fault bits that remain either poison the destination register, by raising a pending-fault set request for that general register, or raise a division interrupt that carries the remaining type. Which of the two happens depends on whether the instruction is non-excepting. The remaining type is always returned.

For a floating-point operation, the block folds the detailed status word into a compact exception mask and a trap-type code. It raises a floating-point interrupt request only when that mask has at least one bit set. All results are registered and appear one clock after the inputs are sampled. Deciding which of the requests is serviced first is left to the interrupt controller downstream.

Top module: `arith_fault_router`

## Requirements
- R1: When `div_valid` is high, `div_type[0]` (overflow) is set and `ovf_mask_en` is high, overflow is cleared from the remaining type and `accum_exc` reads 1 from the next cycle.
- R2: When `div_valid` is high, the remaining type is nonzero and `div_non_exc` is high, then one cycle later `pend_set_valid` pulses with `pend_set_idx` equal to `div_target`, and `div_irq_valid` stays low.
- R3: When `div_valid` is high, the remaining type is nonzero and `div_non_exc` is low, then one cycle later `div_irq_valid` pulses with `div_irq_type` equal to the remaining type, and `pend_set_valid` stays low.
- R4: Every accepted divide gives `div_done` one cycle later, with `div_rem_type` set to the remaining type (bit 0 overflow, bit 1 divide-by-zero). When that type is zero, neither request is raised.
- R5: `accum_exc` holds its value until a write: `sticky_wr_en` loads `sticky_wr_data`. A masked overflow in the same cycle wins and leaves the bit at 1.
- R6: Any of the nine invalid-operation causes in `fp_status[8:0]` sets `fp_irq_mask[0]`.
- R7: `fp_status[9]` divide-by-zero, `[10]` inexact, `[11]` overflow and `[12]` underflow map to `fp_irq_mask[1]`, `[2]`, `[3]` and `[4]`.
- R8: `fp_status[13]` (denormal input) sets `fp_irq_mask[5]` and makes `fp_irq_trap` 2 (denormal code). Otherwise a request carries trap code 1 (IEEE exception).
- R9: `fp_irq_valid` pulses one cycle after `fp_valid` only when the resulting mask is nonzero. Without a request, `fp_irq_mask` and `fp_irq_trap` read 0.
- R10: After reset all outputs read 0. Inputs with their valid low change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| div_valid | input | 1 | Divide fault report present |
| div_type | input | 2 | Divide fault type: bit 0 overflow, bit 1 divide-by-zero |
| div_non_exc | input | 1 | Divide instruction is non-excepting |
| div_target | input | REG_IDX_W | Destination general register index |
| ovf_mask_en | input | 1 | Absorb divide overflow into the sticky bit |
| fp_valid | input | 1 | Floating-point status report present |
| fp_status | input | 14 | Floating-point status causes |
| sticky_wr_en | input | 1 | Software write of the sticky bit |
| sticky_wr_data | input | 1 | Value written to the sticky bit |
| accum_exc | output | 1 | Sticky accumulated-exception bit |
| div_done | output | 1 | Remaining divide type is valid |
| div_rem_type | output | 2 | Remaining divide type |
| pend_set_valid | output | 1 | Set the pending-fault flag of a general register |
| pend_set_idx | output | REG_IDX_W | Register whose pending-fault flag is set |
| div_irq_valid | output | 1 | Division interrupt request |
| div_irq_type | output | 2 | Type carried by the division interrupt |
| fp_irq_valid | output | 1 | Floating-point interrupt request |
| fp_irq_mask | output | 6 | Floating-point exception mask |
| fp_irq_trap | output | 2 | Trap-type code: 1 IEEE, 2 denormal input |

## Verification
The divide side is tried with all four type values crossed with the mask enable and the non-excepting flag. This tells apart an overflow that was absorbed, one that reaches the interrupt, and one that poisons the register, and it also shows that a divide-by-zero is never absorbed. Directed cases put a software clear in the same cycle as a masked overflow, and they drive inputs with the valids low. On the floating-point side, each invalid cause is set alone to prove the nine-way fold. A denormal is sent alone and together with other causes to separate the trap code from the mask, and an all-zero status shows that no interrupt is raised. Random mixes of both sides run against a model of the sticky bit.

// File: rtl/afr_pkg.sv
`timescale 1ns/1ps
package afr_pkg;
  localparam int DIV_TYPE_W  = 2;
  localparam int DIV_OVF_BIT = 0;
  localparam int DIV_DZ_BIT  = 1;

  localparam int FP_INV_CNT  = 9;
  localparam int FP_DIRECT   = 4;
  localparam int FP_STATUS_W = FP_INV_CNT + FP_DIRECT + 1;
  localparam int FP_DENORM   = FP_STATUS_W - 1;
  localparam int FP_MASK_W   = FP_DIRECT + 2;
  localparam int FP_M_INV    = 0;
  localparam int FP_M_DENORM = FP_MASK_W - 1;

  typedef enum logic [1:0] {
    TRAP_NONE   = 2'd0,
    TRAP_IEEE   = 2'd1,
    TRAP_DENORM = 2'd2
  } fp_trap_e;
endpackage

// File: rtl/afr_sticky.sv
`timescale 1ns/1ps
module afr_sticky (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic wr_en_i,
  input  logic wr_data_i,
  output logic acc_o
);
  logic acc_q;

  always_ff @(posedge clk) begin
    if (rst)          acc_q <= 1'b0;
    else if (set_i)   acc_q <= 1'b1;
    else if (wr_en_i) acc_q <= wr_data_i;
  end

  assign acc_o = acc_q;

  // R5: without a set or a write the bit keeps its value
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!set_i && !wr_en_i) |=> (acc_q == $past(acc_q)));
  // R5: a hardware set wins over a simultaneous software write
  a_r5_set_wins: assert property (@(posedge clk) disable iff (rst)
    set_i |=> acc_q);
endmodule

// File: rtl/afr_div_path.sv
`timescale 1ns/1ps
module afr_div_path
  import afr_pkg::*;
#(
  parameter int REG_IDX_W = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  valid_i,
  input  logic [DIV_TYPE_W-1:0] type_i,
  input  logic                  non_exc_i,
  input  logic [REG_IDX_W-1:0]  target_i,
  input  logic                  ovf_mask_en_i,
  output logic                  ovf_absorb_o,
  output logic                  done_o,
  output logic [DIV_TYPE_W-1:0] rem_o,
  output logic                  pend_valid_o,
  output logic [REG_IDX_W-1:0]  pend_idx_o,
  output logic                  irq_valid_o,
  output logic [DIV_TYPE_W-1:0] irq_type_o
);
  logic [DIV_TYPE_W-1:0] rem_c;
  logic                  absorb_c;
  logic                  fault_c;

  always_comb begin
    absorb_c = valid_i && type_i[DIV_OVF_BIT] && ovf_mask_en_i;
    rem_c    = type_i;
    if (absorb_c) rem_c[DIV_OVF_BIT] = 1'b0;
    fault_c  = valid_i && (|rem_c);
  end

  assign ovf_absorb_o = absorb_c;

  always_ff @(posedge clk) begin
    if (rst) begin
      done_o       <= 1'b0;
      rem_o        <= '0;
      pend_valid_o <= 1'b0;
      pend_idx_o   <= '0;
      irq_valid_o  <= 1'b0;
      irq_type_o   <= '0;
    end else begin
      done_o       <= valid_i;
      rem_o        <= valid_i ? rem_c : '0;
      pend_valid_o <= fault_c && non_exc_i;
      pend_idx_o   <= (fault_c && non_exc_i) ? target_i : '0;
      irq_valid_o  <= fault_c && !non_exc_i;
      irq_type_o   <= (fault_c && !non_exc_i) ? rem_c : '0;
    end
  end

  // R2 / R3: a fault goes to exactly one of the two destinations
  a_r3_one_route: assert property (@(posedge clk) disable iff (rst)
    !(pend_valid_o && irq_valid_o));
  // R3: an interrupt always carries a nonzero type
  a_r3_irq_type: assert property (@(posedge clk) disable iff (rst)
    irq_valid_o |-> (irq_type_o != '0));
  // R1: an absorbed overflow never reappears in the remaining type
  a_r1_ovf_gone: assert property (@(posedge clk) disable iff (rst)
    absorb_c |=> !rem_o[DIV_OVF_BIT]);
  // R4: requests only accompany a completed divide
  a_r4_done: assert property (@(posedge clk) disable iff (rst)
    (pend_valid_o || irq_valid_o) |-> done_o);
endmodule

// File: rtl/afr_fp_map.sv
`timescale 1ns/1ps
module afr_fp_map
  import afr_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   valid_i,
  input  logic [FP_STATUS_W-1:0] status_i,
  output logic                   irq_valid_o,
  output logic [FP_MASK_W-1:0]   irq_mask_o,
  output logic [1:0]             irq_trap_o
);
  logic [FP_MASK_W-1:0] mask_c;
  fp_trap_e             trap_c;

  assign mask_c[FP_M_INV]    = |status_i[FP_INV_CNT-1:0];
  assign mask_c[FP_M_DENORM] = status_i[FP_DENORM];

  for (genvar k = 0; k < FP_DIRECT; k++) begin : g_direct
    assign mask_c[FP_M_INV+1+k] = status_i[FP_INV_CNT+k];
  end

  always_comb begin
    trap_c = status_i[FP_DENORM] ? TRAP_DENORM : TRAP_IEEE;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_valid_o <= 1'b0;
      irq_mask_o  <= '0;
      irq_trap_o  <= TRAP_NONE;
    end else if (valid_i && (|mask_c)) begin
      irq_valid_o <= 1'b1;
      irq_mask_o  <= mask_c;
      irq_trap_o  <= trap_c;
    end else begin
      irq_valid_o <= 1'b0;
      irq_mask_o  <= '0;
      irq_trap_o  <= TRAP_NONE;
    end
  end

  // R9: a request always carries a nonzero mask
  a_r9_mask_nz: assert property (@(posedge clk) disable iff (rst)
    irq_valid_o |-> (irq_mask_o != '0));
  // R8: the denormal code appears exactly with the denormal mask bit
  a_r8_trap: assert property (@(posedge clk) disable iff (rst)
    irq_valid_o |-> ((irq_trap_o == TRAP_DENORM) == irq_mask_o[FP_M_DENORM]));
  // R9: no request, no payload
  a_r9_idle: assert property (@(posedge clk) disable iff (rst)
    !irq_valid_o |-> (irq_mask_o == '0 && irq_trap_o == TRAP_NONE));
endmodule

// File: rtl/arith_fault_router.sv
`timescale 1ns/1ps
module arith_fault_router
  import afr_pkg::*;
#(
  parameter int REG_IDX_W = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   div_valid,
  input  logic [DIV_TYPE_W-1:0]  div_type,
  input  logic                   div_non_exc,
  input  logic [REG_IDX_W-1:0]   div_target,
  input  logic                   ovf_mask_en,
  input  logic                   fp_valid,
  input  logic [FP_STATUS_W-1:0] fp_status,
  input  logic                   sticky_wr_en,
  input  logic                   sticky_wr_data,
  output logic                   accum_exc,
  output logic                   div_done,
  output logic [DIV_TYPE_W-1:0]  div_rem_type,
  output logic                   pend_set_valid,
  output logic [REG_IDX_W-1:0]   pend_set_idx,
  output logic                   div_irq_valid,
  output logic [DIV_TYPE_W-1:0]  div_irq_type,
  output logic                   fp_irq_valid,
  output logic [FP_MASK_W-1:0]   fp_irq_mask,
  output logic [1:0]             fp_irq_trap
);
  logic ovf_absorb;

  afr_div_path #(.REG_IDX_W(REG_IDX_W)) u_div (
    .clk           (clk),
    .rst           (rst),
    .valid_i       (div_valid),
    .type_i        (div_type),
    .non_exc_i     (div_non_exc),
    .target_i      (div_target),
    .ovf_mask_en_i (ovf_mask_en),
    .ovf_absorb_o  (ovf_absorb),
    .done_o        (div_done),
    .rem_o         (div_rem_type),
    .pend_valid_o  (pend_set_valid),
    .pend_idx_o    (pend_set_idx),
    .irq_valid_o   (div_irq_valid),
    .irq_type_o    (div_irq_type)
  );

  afr_sticky u_sticky (
    .clk       (clk),
    .rst       (rst),
    .set_i     (ovf_absorb),
    .wr_en_i   (sticky_wr_en),
    .wr_data_i (sticky_wr_data),
    .acc_o     (accum_exc)
  );

  afr_fp_map u_fp (
    .clk         (clk),
    .rst         (rst),
    .valid_i     (fp_valid),
    .status_i    (fp_status),
    .irq_valid_o (fp_irq_valid),
    .irq_mask_o  (fp_irq_mask),
    .irq_trap_o  (fp_irq_trap)
  );

  // R1: the sticky bit rises only from a masked overflow or a software write of 1
  a_r1_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(accum_exc) |-> $past((div_valid && div_type[DIV_OVF_BIT] && ovf_mask_en)
                               || (sticky_wr_en && sticky_wr_data)));
  // R10: divide outputs stay quiet when no divide was presented
  a_r10_div_quiet: assert property (@(posedge clk) disable iff (rst)
    !div_valid |=> (!div_done && !pend_set_valid && !div_irq_valid));
endmodule

// File: tb/arith_fault_router_tb.sv
`timescale 1ns/1ps
module arith_fault_router_tb_top;
  localparam int IW = 6;

  logic          clk = 1'b0;
  logic          rst;
  logic          div_valid, div_non_exc, ovf_mask_en, fp_valid;
  logic [1:0]    div_type;
  logic [IW-1:0] div_target;
  logic [13:0]   fp_status;
  logic          sticky_wr_en, sticky_wr_data;
  logic          accum_exc, div_done, pend_set_valid, div_irq_valid, fp_irq_valid;
  logic [1:0]    div_rem_type, div_irq_type, fp_irq_trap;
  logic [IW-1:0] pend_set_idx;
  logic [5:0]    fp_irq_mask;

  int checks = 0;
  int fails  = 0;
  bit sticky_m = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  arith_fault_router #(.REG_IDX_W(IW)) dut_i (
    .clk(clk), .rst(rst), .div_valid(div_valid), .div_type(div_type),
    .div_non_exc(div_non_exc), .div_target(div_target), .ovf_mask_en(ovf_mask_en),
    .fp_valid(fp_valid), .fp_status(fp_status), .sticky_wr_en(sticky_wr_en),
    .sticky_wr_data(sticky_wr_data), .accum_exc(accum_exc), .div_done(div_done),
    .div_rem_type(div_rem_type), .pend_set_valid(pend_set_valid),
    .pend_set_idx(pend_set_idx), .div_irq_valid(div_irq_valid),
    .div_irq_type(div_irq_type), .fp_irq_valid(fp_irq_valid),
    .fp_irq_mask(fp_irq_mask), .fp_irq_trap(fp_irq_trap)
  );

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  function automatic logic [5:0] exp_mask(logic [13:0] s);
    logic [5:0] m;
    m[0] = |s[8:0];
    m[1] = s[9];  m[2] = s[10];
    m[3] = s[11]; m[4] = s[12];
    m[5] = s[13];
    return m;
  endfunction

  function automatic logic [1:0] exp_rem(logic [1:0] t, logic men);
    return (t[0] && men) ? (t & 2'b10) : t;
  endfunction

  // drive one cycle of stimulus, then check the registered result
  task automatic step(logic dv, logic [1:0] dt, logic ne, logic [IW-1:0] tg, logic men,
                      logic fv, logic [13:0] fs, logic we, logic wd);
    logic [1:0] r;
    logic [5:0] m;
    logic       fault;
    @(negedge clk);
    div_valid = dv; div_type = dt; div_non_exc = ne; div_target = tg; ovf_mask_en = men;
    fp_valid = fv; fp_status = fs; sticky_wr_en = we; sticky_wr_data = wd;
    r = dv ? exp_rem(dt, men) : 2'b00;
    fault = dv && (r != 2'b00);
    m = exp_mask(fs);
    if (dv && dt[0] && men) sticky_m = 1'b1;
    else if (we) sticky_m = wd;
    @(posedge clk);
    @(negedge clk);
    div_valid = 1'b0; fp_valid = 1'b0; sticky_wr_en = 1'b0;
    check("R1 sticky", accum_exc, sticky_m);
    check("R4 done", div_done, dv);
    check("R4 rem_type", div_rem_type, r);
    check("R2 pend_valid", pend_set_valid, fault && ne);
    if (fault && ne) check("R2 pend_idx", pend_set_idx, tg);
    check("R3 irq_valid", div_irq_valid, fault && !ne);
    check("R3 irq_type", div_irq_type, (fault && !ne) ? r : 2'b00);
    check("R9 fp_valid", fp_irq_valid, fv && (m != 0));
    check("R6 R7 fp_mask", fp_irq_mask, (fv && m != 0) ? m : 6'd0);
    check("R8 fp_trap", fp_irq_trap, (fv && m != 0) ? (m[5] ? 2'd2 : 2'd1) : 2'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0017));
    rst = 1'b1;
    div_valid = 0; div_type = 0; div_non_exc = 0; div_target = 0; ovf_mask_en = 0;
    fp_valid = 0; fp_status = 0; sticky_wr_en = 0; sticky_wr_data = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 reset state
    check("R10 reset accum", accum_exc, 0);
    check("R10 reset outputs",
          {div_done, pend_set_valid, div_irq_valid, fp_irq_valid, fp_irq_mask, fp_irq_trap}, 0);
    rst = 1'b0;

    // R3 unmasked overflow traps; R1 masked overflow absorbed
    step(1, 2'b01, 0, 6'd5, 0, 0, 0, 0, 0);
    step(1, 2'b01, 0, 6'd5, 1, 0, 0, 0, 0);
    // R5 sticky holds, then software clears it
    step(0, 2'b00, 0, 6'd0, 0, 0, 0, 0, 0);
    step(0, 2'b00, 0, 6'd0, 0, 0, 0, 1, 0);
    // R5 set wins over a same-cycle clear
    step(1, 2'b11, 1, 6'd9, 1, 0, 0, 1, 0);
    step(0, 2'b00, 0, 6'd0, 0, 0, 0, 1, 0);
    // R2 non-excepting divide-by-zero poisons register 63
    step(1, 2'b10, 1, 6'd63, 0, 0, 0, 0, 0);
    // R4 nothing remains: no request
    step(1, 2'b00, 0, 6'd3, 1, 0, 0, 0, 0);
    // R10 valid low: nothing raised
    step(0, 2'b11, 0, 6'd7, 1, 0, 14'h3fff, 0, 0);
    // R6 each invalid cause alone
    for (int k = 0; k < 9; k++) step(0, 0, 0, 0, 0, 1, 14'(1) << k, 0, 0);
    // R7 each direct cause alone
    for (int k = 9; k < 13; k++) step(0, 0, 0, 0, 0, 1, 14'(1) << k, 0, 0);
    // R8 denormal alone and with others; R9 zero status
    step(0, 0, 0, 0, 0, 1, 14'h2000, 0, 0);
    step(0, 0, 0, 0, 0, 1, 14'h2a01, 0, 0);
    step(0, 0, 0, 0, 0, 1, 14'h0000, 0, 0);
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [13:0] s;
      s = 14'($urandom);
      if (($urandom % 4) == 0) s = 14'(1) << ($urandom % 14);
      step(1'($urandom), 2'($urandom), 1'($urandom), IW'($urandom), 1'($urandom),
           1'($urandom), s, (($urandom % 8) == 0), 1'($urandom));
    end
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule